// File: doc/BRIEF.md
# Modem Ring Status and Request-to-Send Control

This block serves the modem-signal side of a UART. It takes the active-low ring-indicator pin and brings it into the clock domain through a synchroniser chain. It shows the present ring state in a status byte, together with a sticky flag that records the end of a ring burst (the pin returning high). When the modem interrupt is enabled, the same event also raises an interrupt request. Software clears both the flag and the request by reading the status byte.

The block also holds a modem control byte. Its request bit drives the active-low request-to-send output. Three conditions hold that output inactive: master reset, loopback mode, and automatic flow control. Under automatic flow control the output stops whenever the receive FIFO count is at or above the trigger level. It resumes on its own once the count drops below that level, provided the request bit is still set.

Registers are reached through a single-cycle strobe interface. Read data is combinational from the address. Reads have a side effect only when the read strobe is high.

Top module: `modem_ring_rts_ctrl`

## Requirements
- R1: After reset, rts_n is 1, modem_irq is 0, the control byte reads 0x00, and the status byte reads 0x00 while ri_n is held high.
- R2: Status bit 6 is the complement of ri_n. A change on the pin shows up after the second rising clock edge that samples it, and not after the first.
- R3: Status bit 2 is set at the third rising edge after ri_n goes from 0 to 1. A 1-to-0 change on ri_n never sets it.
- R4: A read strobe at the status address (6) clears bit 2 at that clock edge. If a new 0-to-1 event reaches the flag at the same edge, bit 2 stays set.
- R5: modem_irq is set together with bit 2 only if msi_en is 1 at the event. It is cleared by a status read under the same rule as R4, and it stays 0 for events that occur while msi_en is 0.
- R6: A write strobe at the control address (4) stores all eight data bits, and they read back unchanged. Bit 1 is the send request, bit 4 is loopback, and bit 5 enables automatic flow control.
- R7: rts_n is 0 exactly when control bit 1 is 1, bit 4 is 0, and automatic flow control is not holding. Loopback forces rts_n to 1.
- R8: With bit 5 set, the flow hold is taken one clock edge after rx_level >= rx_trig and released one edge after rx_level < rx_trig. With bit 5 clear, rx_level has no effect.
- R9: Writes to any address other than 4 change neither register. A write to the status address leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| reg_addr | input | 3 | Register address (4 = control, 6 = status) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a status read clears the flag and the interrupt |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| msi_en | input | 1 | Modem status interrupt enable |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rts_n | output | 1 | Request to send, active low |
| modem_irq | output | 1 | Modem status interrupt request |

## Verification
The request-to-send output is swept over all eight combinations of request, loopback and auto-enable. For each combination, every fill count from empty to full is applied against a low, a middle and a full trigger level. This separates loopback priority from flow hold, and separates the `>=` boundary from `>`.

All 256 control values are written and read back, and stray writes go to the other addresses. Ring pulses are applied with the interrupt enabled and with it disabled, which tells the gated request apart from the ungated flag. A pulse whose event lands on the same clock edge as a status read shows whether set takes priority over clear.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam logic [2:0] MCR_ADDR = 3'd4;
  localparam logic [2:0] MSR_ADDR = 3'd6;

  localparam int RTS_BIT  = 1;
  localparam int LOOP_BIT = 4;
  localparam int AUTO_BIT = 5;
  localparam int RING_BIT = 6;
  localparam int TERI_BIT = 2;

  // fill count has reached the trigger level
  function automatic logic at_threshold(input logic [15:0] lvl, input logic [15:0] trig);
    return lvl >= trig;
  endfunction

  // status byte from ring level (active high) and trailing-edge flag
  function automatic logic [7:0] msr_pack(input logic ring, input logic teri);
    logic [7:0] b;
    b = 8'h00;
    b[RING_BIT] = ring;
    b[TERI_BIT] = teri;
    return b;
  endfunction

  // active-low request-to-send level
  function automatic logic rts_level_n(input logic req, input logic loop, input logic hold);
    return !(req && !loop && !hold);
  endfunction
endpackage

// File: rtl/ri_sync.sv
module ri_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  // R3
  rise_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/msr_status.sv
module msr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       pin_lvl_i,
  input  logic       msi_en_i,
  input  logic       msr_rd_i,
  output logic [7:0] msr_o,
  output logic       irq_o
);
  logic teri_q;
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      teri_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      teri_q <= rise_i | (teri_q & ~msr_rd_i);
      irq_q  <= (rise_i & msi_en_i) | (irq_q & ~msr_rd_i);
    end

  assign msr_o = mdm_pkg::msr_pack(~pin_lvl_i, teri_q);
  assign irq_o = irq_q;

  // R3
  teri_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> msr_o[mdm_pkg::TERI_BIT]);
  // R4
  teri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_i && !rise_i) |=> !msr_o[mdm_pkg::TERI_BIT]);
  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && msi_en_i) |=> irq_o);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !msi_en_i) |=> !irq_o);
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  output logic [7:0]       mcr_o,
  output logic             rts_n_o
);
  logic [7:0] mcr_q;
  logic       hold_q;
  logic       full_hit;

  assign full_hit = mdm_pkg::at_threshold(16'(rx_level_i), 16'(rx_trig_i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mcr_q <= 8'h00;
    else if (wr_i) mcr_q <= wdata_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= mcr_q[mdm_pkg::AUTO_BIT] & full_hit;

  assign mcr_o   = mcr_q;
  assign rts_n_o = mdm_pkg::rts_level_n(mcr_q[mdm_pkg::RTS_BIT],
                                        mcr_q[mdm_pkg::LOOP_BIT], hold_q);

  // R6
  mcr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mcr_o));
  // R7
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[mdm_pkg::LOOP_BIT]) |=> rts_n_o);
  // R8
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && mcr_o[mdm_pkg::AUTO_BIT] && full_hit) |=> rts_n_o);
  // R8
  flow_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && mcr_o[mdm_pkg::RTS_BIT] && !mcr_o[mdm_pkg::LOOP_BIT] && !full_hit) |=> !rts_n_o);
endmodule

// File: rtl/modem_ring_rts_ctrl.sv
module modem_ring_rts_ctrl #(
  parameter  int RX_DEPTH    = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ri_n,
  input  logic             msi_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_trig,
  output logic             rts_n,
  output logic             modem_irq
);
  logic       ri_lvl;
  logic       ri_rise;
  logic       msr_rd;
  logic       mcr_wr;
  logic [7:0] msr_byte;
  logic [7:0] mcr_byte;

  assign msr_rd = reg_rd && (reg_addr == mdm_pkg::MSR_ADDR);
  assign mcr_wr = reg_wr && (reg_addr == mdm_pkg::MCR_ADDR);

  ri_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ri_n), .level_o(ri_lvl), .rise_o(ri_rise)
  );

  msr_status u_msr (
    .clk(clk), .rst_n(rst_n), .rise_i(ri_rise), .pin_lvl_i(ri_lvl),
    .msi_en_i(msi_en), .msr_rd_i(msr_rd), .msr_o(msr_byte), .irq_o(modem_irq)
  );

  rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .wr_i(mcr_wr), .wdata_i(reg_wdata),
    .rx_level_i(rx_level), .rx_trig_i(rx_trig), .mcr_o(mcr_byte), .rts_n_o(rts_n)
  );

  always_comb begin
    case (reg_addr)
      mdm_pkg::MCR_ADDR: reg_rdata = mcr_byte;
      mdm_pkg::MSR_ADDR: reg_rdata = msr_byte;
      default:           reg_rdata = 8'h00;
    endcase
  end

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != mdm_pkg::MCR_ADDR) |=> $stable(mcr_byte));
endmodule

// File: tb/modem_ring_rts_ctrl_tb_top.sv
`timescale 1ns/1ps
module modem_ring_rts_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          ri_n = 1'b1;
  logic          msi_en = 1'b0;
  logic [CW-1:0] rx_level = '0;
  logic [CW-1:0] rx_trig = CW'(8);
  logic          rts_n;
  logic          modem_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  modem_ring_rts_ctrl #(.RX_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ri_n(ri_n), .msi_en(msi_en),
    .rx_level(rx_level), .rx_trig(rx_trig), .rts_n(rts_n), .modem_irq(modem_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_msr(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 3'd6; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic int exp_msr(input logic pin, input logic teri);
    return (pin ? 0 : 64) + (teri ? 4 : 0);
  endfunction

  initial begin
    #(100000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int trig_set[3];
    trig_set[0] = 1; trig_set[1] = 8; trig_set[2] = DEPTH;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rts_n", int'(rts_n), 1);
    chk("R1 irq", int'(modem_irq), 0);
    peek(3'd4, v); chk("R1 mcr", int'(v), 0);
    peek(3'd6, v); chk("R1 msr", int'(v), 0);
    rst_n = 1'b1;

    // R6 full readback sweep
    for (int d = 0; d < 256; d++) begin
      wr_reg(3'd4, 8'(d));
      peek(3'd4, v); chk("R6 mcr readback", int'(v), d);
    end

    // R9 stray writes
    wr_reg(3'd4, 8'h02);
    for (int a = 0; a < 8; a++) begin
      if (a != 4) begin
        wr_reg(3'(a), 8'hFF);
        peek(3'd4, v); chk("R9 mcr unchanged", int'(v), 2);
        peek(3'd6, v); chk("R9 msr unchanged", int'(v), 0);
        chk("R9 rts_n unchanged", int'(rts_n), 0);
      end
    end

    // R7 R8 exhaustive rts sweep
    for (int m = 0; m < 8; m++) begin
      logic req, lp, au;
      req = m[0]; lp = m[1]; au = m[2];
      wr_reg(3'd4, {2'b00, au, lp, 2'b00, req, 1'b0});
      for (int t = 0; t < 3; t++) begin
        for (int l = 0; l <= DEPTH; l++) begin
          @(negedge clk);
          rx_trig = CW'(trig_set[t]); rx_level = CW'(l);
          @(negedge clk);
          chk(au ? "R8 auto rts_n" : "R7 rts_n", int'(rts_n),
              (req && !lp && (!au || l < trig_set[t])) ? 0 : 1);
        end
      end
    end
    rx_level = '0;
    wr_reg(3'd4, 8'h00);

    // R2 R3 R5 ring pulse with interrupt enabled
    msi_en = 1'b1;
    @(negedge clk); ri_n = 1'b0;
    @(negedge clk); peek(3'd6, v); chk("R2 ring after 1 edge", int'(v), exp_msr(1, 0));
    @(negedge clk); peek(3'd6, v); chk("R2 ring after 2 edges", int'(v), exp_msr(0, 0));
    repeat (3) @(negedge clk);
    peek(3'd6, v); chk("R3 no set on falling pin", int'(v), exp_msr(0, 0));
    chk("R5 no irq on falling pin", int'(modem_irq), 0);
    ri_n = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(3'd6, v); chk("R3 not yet after 2 edges", int'(v), exp_msr(1, 0));
    @(negedge clk);
    peek(3'd6, v); chk("R3 set after 3 edges", int'(v), exp_msr(1, 1));
    chk("R5 irq raised", int'(modem_irq), 1);
    rd_msr(v); chk("R4 read returns flag", int'(v), exp_msr(1, 1));
    peek(3'd6, v); chk("R4 cleared by read", int'(v), exp_msr(1, 0));
    chk("R5 irq cleared by read", int'(modem_irq), 0);

    // R4 R5 event coincides with read
    @(negedge clk); ri_n = 1'b0;
    repeat (4) @(negedge clk);
    ri_n = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_addr = 3'd6; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    peek(3'd6, v); chk("R4 set wins over read", int'(v), exp_msr(1, 1));
    chk("R5 irq set wins over read", int'(modem_irq), 1);
    rd_msr(v);
    chk("R5 irq cleared", int'(modem_irq), 0);

    // R5 ring pulse with interrupt disabled
    msi_en = 1'b0;
    @(negedge clk); ri_n = 1'b0;
    repeat (4) @(negedge clk);
    ri_n = 1'b1;
    repeat (4) @(negedge clk);
    peek(3'd6, v); chk("R5 flag without enable", int'(v), exp_msr(1, 1));
    chk("R5 no irq when disabled", int'(modem_irq), 0);
    msi_en = 1'b1;
    @(negedge clk);
    chk("R5 late enable no irq", int'(modem_irq), 0);
    rd_msr(v);
    peek(3'd6, v); chk("R4 clear", int'(v), exp_msr(1, 0));

    // R1 reset mid-run
    wr_reg(3'd4, 8'h02);
    chk("R7 rts active", int'(rts_n), 0);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 reset rts_n", int'(rts_n), 1);
    peek(3'd4, v); chk("R1 reset mcr", int'(v), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule